// File: doc/BRIEF.md
# Flow-Through Late-Write Synchronous SRAM

This block models a single-port synchronous static memory whose read path has no output register. Once a read has been loaded on a clock edge, the stored word appears on the data outputs during the cycle that follows. Writes are moved one cycle later. A write command only records its address and byte-lane mask in a delay stage, and its data arrives on the next enabled edge. Because of this, a read may follow a write, or a write may follow a read, on every clock with no idle bus cycle between them.

Each enabled edge carries one of four commands: load-read, load-write, deselect, or advance. Advance continues the operation that is already running at the next address of a four-beat burst. The chip enables, the direction bit and the address count only on load cycles. Two inputs gate every edge, a clock enable and a snooze input. The data bus is shown as separate input and output vectors plus a drive flag, and drive flag low stands for high impedance. An asynchronous output enable controls the drive flag.

The full part has 16 address bits. The default `ADDR_W` is 10 so that the model stays small. Setting it to 16 gives the full 65,536-word depth. The word is 36 bits in four 9-bit lanes by default. `DATA_W = 32` gives four 8-bit lanes.

Top module: `ntf_sram`

## Requirements
- R1: After a load-read on an enabled edge, while `oe_n` is 0 and `snooze` is 0, `dq_drive` is 1 and `dq_out` equals the stored word at the loaded address for the whole cycle after that edge.
- R2: The write data for a write command (load or burst) is taken from `dq_in` at the next enabled edge. Lane i is bits [i*DATA_W/LANES +: DATA_W/LANES]. A lane is written only if `byte_we_n[i]` was 0 with the command. Other lanes keep their contents.
- R3: An edge with `cen_n` = 1 changes nothing: address, operation and pending write are held. A pending write then takes its data at the next enabled edge. A read output shows the same word during a stall.
- R4: On a load (`adv_ld` = 0) with every `chip_en` bit at 1, the address is captured. `rw` = 1 starts a read and `rw` = 0 starts a write.
- R5: On an advance (`adv_ld` = 1), `rw`, `chip_en` and `addr` are ignored. The running operation continues at the next burst address, and `byte_we_n` is sampled again for a burst write.
- R6: Beat n of a burst (n = 0..3) keeps the upper address bits. With `lin_burst` = 1 the low two bits are (base + n) mod 4. With `lin_burst` = 0 they are base XOR n.
- R7: `oe_n` = 1 forces `dq_drive` to 0 within the same cycle, with no clock edge needed. Returning it to 0 restores the drive.
- R8: While `snooze` is 1, `dq_drive` is 0 and every other input is ignored. Memory contents are kept.
- R9: A load with any `chip_en` bit at 0 deselects, and `dq_drive` is 0 in the next cycle. A write still pending at that edge completes. An advance after a deselect stays deselected.
- R10: A read loaded on the edge right after a write command to the same address returns the new data. Reads and writes can alternate on consecutive edges.
- R11: After reset, `dq_drive` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| cen_n | input | 1 | Active-low clock enable; 1 masks the edge |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| rw | input | 1 | Direction on load: 1 read, 0 write |
| chip_en | input | CE_N | Chip enables, all must be 1 on load to select |
| addr | input | ADDR_W | Word address, used on load |
| byte_we_n | input | LANES | Active-low byte-lane write enables |
| lin_burst | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| snooze | input | 1 | Power-down: gates the clock and releases the bus |
| dq_in | input | DATA_W | Write data, one enabled edge after its command |
| dq_out | output | DATA_W | Read data, flow-through from the array |
| dq_drive | output | 1 | 1 when the block drives the data bus |

## Verification
One enabled edge can commit the data of an earlier write and also load a read of that same address. This has to give the new word with no bypass path. The bench issues a write command and then, on the very next edge, a read of the same location while it puts that write's data on `dq_in`. The read output in the following cycle is compared with a reference array that applies the commit before the read. A second kind of overlap is a stall or a deselect that arrives while a write is still pending. The bench checks this by reading the affected words back later.

// File: rtl/ntf_pkg.sv
`timescale 1ns/1ps
package ntf_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits for beat n of a four-beat burst.
  function automatic logic [1:0] burst_step(input logic [1:0] base,
                                            input logic [1:0] n,
                                            input logic       linear);
    logic [1:0] sum;
    sum = base + n;
    return linear ? sum : (base ^ n);
  endfunction

endpackage

// File: rtl/ntf_burst_ctr.sv
`timescale 1ns/1ps
module ntf_burst_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              load,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);
  import ntf_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_inc;

  assign cnt_inc  = cnt_q + 2'd1;
  assign cur_addr = {base_q[ADDR_W-1:2], burst_step(base_q[1:0], cnt_q, linear)};
  assign nxt_addr = load ? addr_in
                         : {base_q[ADDR_W-1:2], burst_step(base_q[1:0], cnt_inc, linear)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step_en) begin
      if (load) begin
        base_q <= addr_in;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/ntf_write_delay.sv
`timescale 1ns/1ps
module ntf_write_delay #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LANES-1:0]  lane_we_n,
  output logic              pend_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  lanes_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      addr_q  <= '0;
      lanes_q <= '0;
    end else if (step_en) begin
      pend_q <= capture;
      if (capture) begin
        addr_q  <= addr_in;
        lanes_q <= ~lane_we_n;
      end
    end
  end
endmodule

// File: rtl/ntf_array.sv
`timescale 1ns/1ps
module ntf_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end
    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/ntf_sram.sv
`timescale 1ns/1ps
module ntf_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36,
  parameter int LANES  = 4,
  parameter int CE_N   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              adv_ld,
  input  logic              rw,
  input  logic [CE_N-1:0]   chip_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_we_n,
  input  logic              lin_burst,
  input  logic              oe_n,
  input  logic              snooze,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  import ntf_pkg::*;

  // Named internal events
  logic              edge_en;
  logic              is_load;
  logic              sel_all;
  logic              cmd_write;
  logic              commit;
  logic              read_live;
  op_e               op_q, next_op;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic              wr_pend;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_lanes;
  logic [DATA_W-1:0] rd_data;

  assign edge_en = !cen_n && !snooze;
  assign is_load = !adv_ld;
  assign sel_all = &chip_en;

  always_comb begin
    next_op = op_q;
    if (is_load) begin
      if (!sel_all) next_op = OP_IDLE;
      else          next_op = rw ? OP_READ : OP_WRITE;
    end
  end

  assign cmd_write = (next_op == OP_WRITE);
  assign commit    = edge_en && wr_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       op_q <= OP_IDLE;
    else if (edge_en) op_q <= next_op;
  end

  ntf_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (edge_en),
    .load     (is_load),
    .linear   (lin_burst),
    .addr_in  (addr),
    .cur_addr (cur_addr),
    .nxt_addr (nxt_addr)
  );

  ntf_write_delay #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wdly (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (edge_en),
    .capture   (cmd_write),
    .addr_in   (nxt_addr),
    .lane_we_n (byte_we_n),
    .pend_q    (wr_pend),
    .addr_q    (wr_addr),
    .lanes_q   (wr_lanes)
  );

  ntf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_array (
    .clk      (clk),
    .wr_en    (commit),
    .wr_addr  (wr_addr),
    .wr_lanes (wr_lanes),
    .wr_data  (dq_in),
    .rd_addr  (cur_addr),
    .rd_data  (rd_data)
  );

  assign read_live = (op_q == OP_READ);
  assign dq_drive  = read_live && !oe_n && !snooze;
  assign dq_out    = dq_drive ? rd_data : '0;
endmodule

// File: rtl/ntf_sram_chk.sv
`timescale 1ns/1ps
module ntf_sram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              edge_en,
  input logic              adv_ld,
  input logic              sel_all,
  input logic              cmd_write,
  input logic              wr_pend,
  input logic [1:0]        op,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [ADDR_W-1:0] addr,
  input logic              dq_drive
);
  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_en |=> $stable(cur_addr) && $stable(wr_pend) && $stable(op));

  a_r4_load_takes_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_en && !adv_ld && sel_all) |=> cur_addr == $past(addr));

  a_r5_advance_keeps_op: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_en && adv_ld) |=> $stable(op));

  a_r2_write_goes_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_en && cmd_write) |=> wr_pend);

  a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_en && !adv_ld && !sel_all) |=> !dq_drive);
endmodule

bind ntf_sram ntf_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .edge_en   (edge_en),
  .adv_ld    (adv_ld),
  .sel_all   (sel_all),
  .cmd_write (cmd_write),
  .wr_pend   (wr_pend),
  .op        (op_q),
  .cur_addr  (cur_addr),
  .addr      (addr),
  .dq_drive  (dq_drive)
);

// File: tb/ntf_sram_bench.sv
`timescale 1ns/1ps
module ntf_sram_bench;
  localparam int AW = 10, DW = 36, LN = 4, LW = DW / LN, CE = 3;
  localparam int K_RD = 0, K_WR = 1, K_ADV = 2, K_DSEL = 3, K_STALL = 4, K_SNZ = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cen_n, adv_ld, rw, lin_burst, oe_n, snooze, dq_drive;
  logic [CE-1:0] chip_en;
  logic [AW-1:0] addr;
  logic [LN-1:0] byte_we_n;
  logic [DW-1:0] dq_in, dq_out;

  ntf_sram u_ntf_sram (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld(adv_ld), .rw(rw),
    .chip_en(chip_en), .addr(addr), .byte_we_n(byte_we_n), .lin_burst(lin_burst),
    .oe_n(oe_n), .snooze(snooze), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  int checks = 0, errs = 0, pe = 0;
  always @(posedge clk) pe <= pe + 1;

  // scoreboard queues
  int            q_due[$];
  logic          q_drv[$];
  logic [DW-1:0] q_dat[$];
  string         q_tag[$];

  // reference state
  logic [DW-1:0] rm [0:(1<<AW)-1];
  int            b_op = 0, b_n = 0;
  logic [AW-1:0] b_base = '0, b_wa = '0;
  logic          b_pend = 1'b0;
  logic [LN-1:0] b_wm = '0;

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] base, int n, logic lin);
    int lo;
    lo = lin ? (int'(base[1:0]) + n) % 4 : (int'(base[1:0]) ^ (n % 4));
    return {base[AW-1:2], 2'(lo)};
  endfunction

  task automatic report(string tag, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic drv, logic [DW-1:0] d, string tag);
    q_due.push_back(pe + 1); q_drv.push_back(drv); q_dat.push_back(d); q_tag.push_back(tag);
  endtask

  // monitor: samples at the falling edge, before the driver moves inputs
  initial begin
    forever begin
      @(negedge clk);
      while (q_due.size() > 0 && q_due[0] <= pe) begin
        int d; logic v; logic [DW-1:0] x; string t;
        d = q_due.pop_front(); v = q_drv.pop_front(); x = q_dat.pop_front(); t = q_tag.pop_front();
        if (d < pe) report({t, " missed"}, '1, '0);
        else if (v) report(t, {dq_drive, dq_out}, {1'b1, x});
        else        report(t, {dq_drive, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});
      end
    end
  end

  // driver with requirement-level reference model
  task automatic cyc(int k, logic [AW-1:0] a, logic [LN-1:0] ben, logic [DW-1:0] wd, string tag);
    logic [AW-1:0] cur;
    @(negedge clk); #0.5;
    cen_n = 1'b0; snooze = 1'b0; dq_in = wd; byte_we_n = ben; oe_n = 1'b0;
    case (k)
      K_RD:    begin adv_ld = 0; rw = 1; chip_en = '1; addr = a; end
      K_WR:    begin adv_ld = 0; rw = 0; chip_en = '1; addr = a; end
      K_ADV:   begin adv_ld = 1; rw = 0; chip_en = '0; addr = ~a; end
      K_DSEL:  begin adv_ld = 0; rw = 1; chip_en = 3'b101; addr = a; end
      K_STALL: begin cen_n = 1; adv_ld = 0; rw = 0; chip_en = '1; addr = a; byte_we_n = '0; end
      default: begin snooze = 1; adv_ld = 0; rw = 0; chip_en = '1; addr = a; byte_we_n = '0; end
    endcase
    if (k == K_STALL || k == K_SNZ) begin
      cur = beat_addr(b_base, b_n, lin_burst);
      if (k == K_STALL && b_op == 1) push(1'b1, rm[cur], tag);
      else                           push(1'b0, '0, tag);
    end else begin
      if (b_pend)
        for (int i = 0; i < LN; i++)
          if (b_wm[i]) rm[b_wa][i*LW +: LW] = wd[i*LW +: LW];
      case (k)
        K_RD:   begin b_op = 1; b_base = a; b_n = 0; end
        K_WR:   begin b_op = 2; b_base = a; b_n = 0; end
        K_DSEL: begin b_op = 0; b_base = a; b_n = 0; end
        default: b_n++;
      endcase
      cur = beat_addr(b_base, b_n, lin_burst);
      b_pend = (b_op == 2);
      if (b_pend) begin b_wa = cur; b_wm = ~ben; end
      if (b_op == 1) push(1'b1, rm[cur], tag);
      else           push(1'b0, '0, tag);
    end
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return DW'(64'h9_1357_2468) ^ DW'(i * 36'h1_0F0E_0D0C);
  endfunction

  initial begin
    #(4 * 20000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cen_n = 0; adv_ld = 0; rw = 1; chip_en = '0; addr = '0; byte_we_n = '1;
    lin_burst = 0; oe_n = 0; snooze = 0; dq_in = '0;
    repeat (3) @(negedge clk);
    #0.5 report("R11 reset drive", {dq_drive, {DW{1'b0}}}, '0);
    rst_n = 1;
    // writes, including an interleaved burst write ending in a deselect (R2 R5 R9)
    cyc(K_WR, 10'h010, '0, '0, "R2");
    cyc(K_WR, 10'h011, '0, pat(1), "R2");
    cyc(K_WR, 10'h021, '0, pat(2), "R5");
    cyc(K_ADV, 10'h3FF, '0, pat(3), "R5");
    cyc(K_ADV, 10'h3FF, '0, pat(4), "R5");
    cyc(K_ADV, 10'h3FF, '0, pat(5), "R5");
    cyc(K_DSEL, 10'h000, '1, pat(6), "R9 deselect");
    // flow-through reads and interleaved burst read (R1 R6)
    cyc(K_RD, 10'h010, '1, '0, "R1");
    cyc(K_RD, 10'h011, '1, '0, "R1");
    cyc(K_RD, 10'h021, '1, '0, "R6 interleaved");
    cyc(K_ADV, 10'h000, '1, '0, "R6 interleaved");
    cyc(K_ADV, 10'h000, '1, '0, "R6 interleaved");
    cyc(K_ADV, 10'h000, '1, '0, "R6 interleaved");
    // alternating write/read with no gap, same address (R10 R4)
    cyc(K_WR, 10'h030, '0, '0, "R4");
    cyc(K_RD, 10'h030, '1, pat(7), "R10");
    cyc(K_WR, 10'h031, '0, '0, "R4");
    cyc(K_RD, 10'h010, '1, pat(8), "R10");
    cyc(K_RD, 10'h031, '1, '0, "R10");
    // byte-lane mask: lanes 0 and 2 written (R2)
    cyc(K_WR, 10'h010, 4'b1010, '0, "R2");
    cyc(K_DSEL, 10'h000, '1, pat(9), "R9");
    cyc(K_RD, 10'h010, '1, '0, "R2 lane mask");
    // asynchronous output enable (R7)
    @(posedge clk); #0.5 oe_n = 1; #0.1;
    report("R7 oe off", {dq_drive, {DW{1'b0}}}, '0);
    oe_n = 0; #0.1;
    report("R7 oe on", {dq_drive, dq_out}, {1'b1, rm[10'h010]});
    // linear burst read with a stall in the middle (R3 R6)
    lin_burst = 1;
    cyc(K_RD, 10'h022, '1, '0, "R6 linear");
    cyc(K_ADV, 10'h000, '1, '0, "R6 linear");
    cyc(K_STALL, 10'h000, '1, '0, "R3 stall read");
    cyc(K_ADV, 10'h000, '1, '0, "R6 linear");
    cyc(K_ADV, 10'h000, '1, '0, "R6 linear");
    // linear burst write with a stall while a write is pending (R3)
    cyc(K_WR, 10'h041, '0, '0, "R3");
    cyc(K_ADV, 10'h000, '0, pat(10), "R3");
    cyc(K_STALL, 10'h041, '0, pat(99), "R3 stall write");
    cyc(K_ADV, 10'h000, '0, pat(11), "R3");
    cyc(K_DSEL, 10'h000, '1, pat(12), "R3");
    cyc(K_RD, 10'h041, '1, '0, "R3 readback");
    cyc(K_ADV, 10'h000, '1, '0, "R3 readback");
    cyc(K_ADV, 10'h000, '1, '0, "R3 readback");
    // snooze ignores a write command and releases the bus (R8)
    cyc(K_RD, 10'h010, '1, '0, "R8");
    cyc(K_SNZ, 10'h010, '0, pat(50), "R8 snooze");
    cyc(K_SNZ, 10'h010, '0, pat(51), "R8 snooze");
    cyc(K_RD, 10'h010, '1, pat(52), "R8 retained");
    cyc(K_RD, 10'h011, '1, pat(53), "R8 retained");
    // advance after deselect stays deselected (R9)
    cyc(K_DSEL, 10'h010, '1, '0, "R9");
    cyc(K_ADV, 10'h000, '1, '0, "R9 advance");
    cyc(K_RD, 10'h022, '1, '0, "R1");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule